// File: doc/BRIEF.md
# One-Time-Programmable Byte Array with Identifier Readout

This block is a synthesizable stand-in for a byte-wide, one-time-programmable memory with fewer locations than a full-size part. The control pins are an active-low chip select, an active-low output enable and an address bus. Digital flags take the place of the high-voltage levels. One flag selects program mode. A second flag asks the part for its identity. Bidirectional data is split into an input byte, an output byte and an output-drive enable. Analog levels, currents and pin timing are not modelled.

The array holds all ones when it leaves reset or is bulk-erased. A program operation can only clear bits: the location keeps the AND of its old contents and the presented byte. In identifier mode the part returns one of two fixed bytes, selected by the lowest address bit. The top bit of each byte is forced so that the byte has odd parity. Read data and the output-drive enable are registered, so a read has one cycle of latency, in place of the access time.

Top module: `otp_prom_array`

## Requirements
- R1: After reset, or after a one-cycle pulse on `bulk_erase`, every location reads as all ones.
- R2: A cycle with `chip_en_n`=0, `out_en_n`=0, `prog_hv`=0 and `bulk_erase`=0 is a read. On the next cycle `dout_en`=1 and `dout` holds the addressed byte, unless R8 applies.
- R3: A cycle with `chip_en_n`=1 and `prog_hv`=0 is standby. On the next cycle `dout_en`=0 and `dout`=0, whatever the level of `out_en_n`.
- R4: A cycle with `chip_en_n`=0, `out_en_n`=1 and `prog_hv`=0 gives `dout_en`=0 and `dout`=0 on the next cycle.
- R5: A cycle with `prog_hv`=1 and `chip_en_n`=0 stores the bitwise AND of the old contents and `din` at `addr`. On the next cycle `dout_en`=0.
- R6: A cycle with `prog_hv`=1 and `chip_en_n`=1 is inhibited and leaves the array unchanged.
- R7: Programming never turns a 0 bit back into a 1. Programming 0xFF leaves a location unchanged.
- R8: Identifier mode is a read cycle with `id_hv`=1 and address bits above bit 0 all zero. On the next cycle, `addr[0]`=0 returns the manufacturer byte and `addr[0]`=1 returns the device byte.
- R9: Each identifier byte has odd parity over 8 bits. Bit 7 is the parity bit and bits 6..0 come from parameters (defaults 0x01 and 0x11, which give 0x01 and 0x91).
- R10: A read with `id_hv`=1 and any address bit above bit 0 set returns array data, not an identifier byte.
- R11: `bulk_erase` has priority over every other input. In that cycle nothing is programmed, and on the next cycle `dout_en`=0.
- R12: `prog_hv`=1 has priority over `id_hv`. A program cycle with both flags set writes the array and drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also returns the array to the erased state |
| bulk_erase | input | 1 | One-cycle request to return every location to all ones |
| chip_en_n | input | 1 | Active-low chip select; in program mode, a low level programs |
| out_en_n | input | 1 | Active-low output enable |
| prog_hv | input | 1 | Flag standing in for program voltage on the output-enable pin |
| id_hv | input | 1 | Flag standing in for high voltage on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| dout | output | DATA_W | Registered read data, zero when not driven |
| dout_en | output | 1 | Output-drive enable for the data bus |

## Verification
On every cycle the assertions check the output-drive rules: standby, outputs disabled, program, inhibit and erase cycles must leave `dout_en` low, and a read must raise it. They also check that any identifier byte on the bus has odd parity. Stored contents are beyond the assertions. AND accumulation across repeated programs, the array left untouched by inhibited cycles, erase restoring all ones, and the split between identifier and array data on the upper address bits can only be shown by the bench's full address sweeps against its own model of the array.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_READ    = 3'd1,
    M_IDENT   = 3'd2,
    M_OUTOFF  = 3'd3,
    M_PROGRAM = 3'd4,
    M_INHIBIT = 3'd5,
    M_ERASE   = 3'd6
  } otp_mode_e;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              bulk_erase,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              prog_hv,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  output otp_pkg::otp_mode_e mode
);
  import otp_pkg::*;

  logic upper_clear;
  assign upper_clear = (addr[ADDR_W-1:1] == '0);

  always_comb begin
    if (bulk_erase)                 mode = M_ERASE;
    else if (prog_hv)               mode = chip_en_n ? M_INHIBIT : M_PROGRAM;
    else if (chip_en_n)             mode = M_STANDBY;
    else if (out_en_n)              mode = M_OUTOFF;
    else if (id_hv && upper_clear)  mode = M_IDENT;
    else                            mode = M_READ;
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_all,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [DATA_W-1:0] current;

  // A location not written since the last erase reads as all ones.
  assign current = written[addr] ? cells[addr] : {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= current & wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || erase_all) written <= '0;
    else if (wr_en)       written[addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    rd_data <= current;
  end

endmodule

// File: rtl/otp_id_source.sv
module otp_id_source #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-2:0] MFR_LOW  = 7'h01,
  parameter logic [DATA_W-2:0] DEV_LOW  = 7'h11
) (
  input  logic              sel_dev,
  output logic [DATA_W-1:0] id_byte
);
  logic [DATA_W-2:0] low_bits;
  assign low_bits = sel_dev ? DEV_LOW : MFR_LOW;
  // Top bit set when the low bits hold an even count of ones.
  assign id_byte  = {~(^low_bits), low_bits};

endmodule

// File: rtl/otp_prom_array.sv
module otp_prom_array #(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-2:0] MFR_LOW = 7'h01,
  parameter logic [DATA_W-2:0] DEV_LOW = 7'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bulk_erase,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              prog_hv,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  import otp_pkg::*;

  otp_mode_e         mode;
  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] id_byte;
  logic [DATA_W-1:0] id_q;
  logic              drive_q;
  logic              ident_q;

  otp_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bulk_erase (bulk_erase),
    .chip_en_n  (chip_en_n),
    .out_en_n   (out_en_n),
    .prog_hv    (prog_hv),
    .id_hv      (id_hv),
    .addr       (addr),
    .mode       (mode)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk       (clk),
    .rst       (rst),
    .erase_all (mode == M_ERASE),
    .wr_en     (mode == M_PROGRAM),
    .addr      (addr),
    .wr_data   (din),
    .rd_data   (arr_q)
  );

  otp_id_source #(.DATA_W(DATA_W), .MFR_LOW(MFR_LOW), .DEV_LOW(DEV_LOW)) u_id (
    .sel_dev (addr[0]),
    .id_byte (id_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      ident_q <= 1'b0;
      id_q    <= '0;
    end else begin
      drive_q <= (mode == M_READ) || (mode == M_IDENT);
      ident_q <= (mode == M_IDENT);
      id_q    <= id_byte;
    end
  end

  assign dout_en = drive_q;
  assign dout    = !drive_q ? '0 : (ident_q ? id_q : arr_q);

endmodule

// File: rtl/otp_prom_checker.sv
module otp_prom_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bulk_erase,
  input logic              chip_en_n,
  input logic              out_en_n,
  input logic              prog_hv,
  input logic              id_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
    (!bulk_erase && !prog_hv && !chip_en_n && !out_en_n) |=> dout_en);

  a_r3_standby_hiz: assert property (@(posedge clk) disable iff (rst)
    (!bulk_erase && !prog_hv && chip_en_n) |=> (!dout_en && dout == '0));

  a_r4_outoff_hiz: assert property (@(posedge clk) disable iff (rst)
    (!bulk_erase && !prog_hv && !chip_en_n && out_en_n) |=> (!dout_en && dout == '0));

  a_r5_program_quiet: assert property (@(posedge clk) disable iff (rst)
    (!bulk_erase && prog_hv) |=> !dout_en);

  a_r9_id_odd_parity: assert property (@(posedge clk) disable iff (rst)
    (!bulk_erase && !prog_hv && !chip_en_n && !out_en_n && id_hv &&
     addr[ADDR_W-1:1] == '0) |=> (dout_en && $countones(dout) % 2 == 1));

  a_r11_erase_quiet: assert property (@(posedge clk) disable iff (rst)
    bulk_erase |=> !dout_en);

endmodule

bind otp_prom_array otp_prom_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bulk_erase (bulk_erase),
  .chip_en_n  (chip_en_n),
  .out_en_n   (out_en_n),
  .prog_hv    (prog_hv),
  .id_hv      (id_hv),
  .addr       (addr),
  .dout       (dout),
  .dout_en    (dout_en)
);

// File: tb/tb_otp_prom_array.sv
module tb_otp_prom_array;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, bulk_erase, chip_en_n, out_en_n, prog_hv, id_hv;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [DEPTH];

  always #10 clk = ~clk;

  otp_prom_array #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .bulk_erase(bulk_erase), .chip_en_n(chip_en_n),
    .out_en_n(out_en_n), .prog_hv(prog_hv), .id_hv(id_hv), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] with_odd_parity(input logic [6:0] low);
    int ones = 0;
    for (int i = 0; i < 7; i++) ones += low[i];
    return {((ones % 2) == 0) ? 1'b1 : 1'b0, low};
  endfunction

  task automatic idle();
    bulk_erase = 0; chip_en_n = 1; out_en_n = 1; prog_hv = 0; id_hv = 0; din = '0;
  endtask

  task automatic do_read(input int a, input bit idf, input logic [7:0] exp, input string req);
    chip_en_n = 0; out_en_n = 0; prog_hv = 0; id_hv = idf; addr = AW'(a);
    @(negedge clk);
    chk(dout_en === 1'b1 && dout === exp, req, {dout_en, dout}, {1'b1, exp});
    idle();
  endtask

  task automatic do_prog(input int a, input logic [7:0] d, input bit idf, input string req);
    prog_hv = 1; chip_en_n = 0; out_en_n = 1; id_hv = idf; addr = AW'(a); din = d;
    @(negedge clk);
    model[a] = model[a] & d;
    chk(dout_en === 1'b0, req, {8'h0, dout_en}, 9'h0);
    idle();
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) do_read(a, 1'b0, model[a], req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(); addr = '0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(dout_en === 1'b0 && dout === 8'h00, "R1 reset outputs", {dout_en, dout}, 9'h0);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    sweep("R1 R2 erased read");

    // R5: first program pass
    for (int a = 0; a < DEPTH; a++) do_prog(a, 8'((a * 37 + 5) & 8'hFF), 1'b0, "R5 program quiet");
    sweep("R5 R2 readback");
    // R7: second pass ANDs, then 0xFF pass changes nothing
    for (int a = 0; a < DEPTH; a++) do_prog(a, 8'(a) ^ 8'h5A, 1'b0, "R7 program quiet");
    for (int a = 0; a < DEPTH; a += 3) do_prog(a, 8'hFF, 1'b0, "R7 ff program");
    sweep("R7 AND accumulate");

    // R6: inhibited cycles with data zero
    for (int a = 0; a < DEPTH; a++) begin
      prog_hv = 1; chip_en_n = 1; addr = AW'(a); din = 8'h00;
      @(negedge clk);
      chk(dout_en === 1'b0, "R6 inhibit quiet", {8'h0, dout_en}, 9'h0);
      idle();
    end
    sweep("R6 inhibit unchanged");

    // R3 / R4
    for (int v = 0; v < 2; v++) begin
      chip_en_n = 1; out_en_n = v[0]; addr = 8'h10;
      @(negedge clk);
      chk(dout_en === 1'b0 && dout === 8'h00, "R3 standby", {dout_en, dout}, 9'h0);
    end
    chip_en_n = 0; out_en_n = 1; id_hv = 1; addr = 8'h01;
    @(negedge clk);
    chk(dout_en === 1'b0 && dout === 8'h00, "R4 output off", {dout_en, dout}, 9'h0);
    idle();

    // R8 / R9 / R10
    do_read(0, 1'b1, with_odd_parity(7'h01), "R8 R9 manufacturer byte");
    do_read(1, 1'b1, with_odd_parity(7'h11), "R8 R9 device byte");
    for (int a = 2; a < DEPTH; a++) do_read(a, 1'b1, model[a], "R10 id with upper bits");

    // R12: program with both flags
    do_prog(0, 8'h00, 1'b1, "R12 program over id");
    do_read(0, 1'b0, 8'h00, "R12 array written");

    // R11: erase with a program attempt in the same cycle
    bulk_erase = 1; prog_hv = 1; chip_en_n = 0; addr = 8'h03; din = 8'h00;
    @(negedge clk);
    chk(dout_en === 1'b0, "R11 erase quiet", {8'h0, dout_en}, 9'h0);
    idle();
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    sweep("R11 R1 erased again");
    do_prog(7, 8'hC3, 1'b0, "R11 program after erase");
    do_read(7, 1'b0, 8'hC3, "R11 fresh value");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule